// File: doc/BRIEF.md
# Teletext Bit Insertion Pacer

The pacer takes in a serial teletext bit stream that arrives at 6.9375 Mbps. All of its logic runs on a 27 MHz pixel clock. The ratio of the two rates is not a whole number, so the pacer holds each incoming bit for either three or four clocks. It follows a fixed pattern that fits 37 bits into exactly 144 clocks. It samples each bit once, at the end of its hold, and presents the bits of a line one at a time as a valid-qualified stream with a running index. A line is 360 bits long.

A one-cycle line-start pulse from the video timing logic opens a line. The pacer also drives a request strobe that tells the upstream source when to send data. In line mode the strobe is a single pulse ahead of the first bit. In bit mode it marks every bit period on a schedule that runs ahead of the data schedule. Both the lead and the width of the strobe are programmable. One of three input pins is selected as the data source, and a fourth select code feeds constant zeros.

Top module: `ttx_pacer`

## Requirements
- R1: Bits are numbered from 0 and taken in groups of 37. Within a group, the bits at offsets 9, 18, 27 and 36 (0-based) are held for 3 clocks and all other bits for 4, so each group spans 144 clocks.
- R2: The first bit period begins `cfg_req_lead` clocks after the cycle that follows an accepted line-start. Each bit is sampled on the last clock of its hold. In the next cycle the pacer drives `bit_valid` high for one cycle, with the sampled value on `bit_data` and the bit number (0 to 359) on `bit_idx`.
- R3: After bit 359 the pacer returns to idle. It emits no further `bit_valid` and no request until a new line-start is accepted.
- R4: A line-start pulse that arrives while a line is in progress (lead or data phase) is ignored and does not disturb the timing.
- R5: While `cfg_en` is low, line-start is ignored. Dropping `cfg_en` during a line aborts that line, and from the next cycle on `bit_valid` and `req_o` stay low.
- R6: `cfg_src_sel` chooses the data pin: 0 selects `src_pins[0]`, 1 selects `src_pins[1]` and 2 selects `src_pins[2]`. Code 3 selects no pin, and every bit then reads as 0.
- R7: When `cfg_req_mode`=0 (line mode), `req_o` is high for `cfg_req_len` clocks, starting in the cycle after an accepted line-start, so it leads the first bit by `cfg_req_lead` clocks.
- R8: When `cfg_req_mode`=1 (bit mode), a request schedule with the same 3/4-clock pattern starts in the cycle after line-start, `cfg_req_lead` clocks ahead of the data schedule. `req_o` is high during the first `cfg_req_len` clocks of each of its bit periods, and is capped at the length of that period.
- R9: After reset, `req_o`, `bit_valid`, `bit_data` and `bit_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Insertion enable |
| cfg_src_sel | input | 2 | Data pin select (3 = none) |
| cfg_req_mode | input | 1 | 0 = line request, 1 = bit request |
| cfg_req_lead | input | OFS_W (6) | Clocks by which the request leads the data |
| cfg_req_len | input | OFS_W (6) | Request width in clocks |
| line_start | input | 1 | One-cycle pulse that opens a teletext line |
| src_pins | input | N_SRC (3) | Candidate serial data pins |
| req_o | output | 1 | Request strobe to the upstream source |
| bit_valid | output | 1 | One-cycle strobe for each captured bit |
| bit_data | output | 1 | Captured bit value |
| bit_idx | output | 9 | Index of the captured bit within the line |

## Verification
The bench builds the block with its default parameters: 360 bits per line, groups of 37 bits with a short hold every ninth bit, and 6-bit lead and width fields. With these values one line contains nine full groups and a final partial group of 27 bits. A lead of 63, the largest the field can hold, is within reach, as is a width longer than any bit period. Each selected pin is driven with a bit pattern and the unselected pins with its inverse, so picking the wrong pin changes the captured data. Line and bit request modes, a line-start in the middle of a line, and an abort followed by a restart are all run against a schedule computed in the bench.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_DATA = 2'd2
  } line_st_t;

  localparam logic REQ_LINE = 1'b0;
  localparam logic REQ_BIT  = 1'b1;
endpackage

// File: rtl/ttx_bit_timer.sv
module ttx_bit_timer #(
  parameter int LINE_BITS    = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_HOLD    = 4,
  parameter int SHORT_HOLD   = 3,
  localparam int IDX_W = $clog2(LINE_BITS),
  localparam int POS_W = $clog2(GROUP_BITS),
  localparam int PH_W  = $clog2(LONG_HOLD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  output logic             active,
  output logic [PH_W-1:0]  phase,
  output logic [IDX_W-1:0] idx,
  output logic             bit_end,
  output logic             line_end
);
  logic [POS_W-1:0] pos;
  logic             active_n;
  logic [PH_W-1:0]  phase_n;
  logic [IDX_W-1:0] idx_n;
  logic [POS_W-1:0] pos_n;
  logic             short_bit;
  logic [PH_W-1:0]  hold_m1;

  // hold length of the bit at the current group offset
  always_comb begin
    short_bit = (pos != '0) && ((int'(pos) % SHORT_STRIDE) == 0);
    hold_m1   = short_bit ? PH_W'(SHORT_HOLD - 1) : PH_W'(LONG_HOLD - 1);
    bit_end   = active && (phase == hold_m1);
    line_end  = bit_end && (idx == IDX_W'(LINE_BITS - 1));
  end

  always_comb begin
    active_n = active;
    phase_n  = phase;
    idx_n    = idx;
    pos_n    = pos;
    if (clr) begin
      active_n = 1'b0;
      phase_n  = '0;
      idx_n    = '0;
      pos_n    = '0;
    end else if (!active) begin
      if (start) begin
        active_n = 1'b1;
        phase_n  = '0;
        idx_n    = '0;
        pos_n    = '0;
      end
    end else if (bit_end) begin
      phase_n = '0;
      if (line_end) begin
        active_n = 1'b0;
      end else begin
        idx_n = idx + 1'b1;
        pos_n = (pos == POS_W'(GROUP_BITS - 1)) ? '0 : pos + 1'b1;
      end
    end else begin
      phase_n = phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
      idx    <= '0;
      pos    <= '0;
    end else begin
      active <= active_n;
      phase  <= phase_n;
      idx    <= idx_n;
      pos    <= pos_n;
    end
  end
endmodule

// File: rtl/ttx_src_mux.sv
module ttx_src_mux #(
  parameter int N_SRC = 3,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] pins,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  always_comb begin
    dout = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) dout = pins[i];
    end
  end
endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen #(
  parameter int OFS_W = 6,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             mode,
  input  logic [OFS_W-1:0] len,
  input  logic             sched_active,
  input  logic [PH_W-1:0]  sched_phase,
  output logic             req
);
  import ttx_pkg::*;

  logic [OFS_W-1:0] age;
  logic [OFS_W-1:0] age_n;
  logic             age_en;

  always_comb begin
    age_en = start || (busy && (age != '1));
    age_n  = start ? '0 : age + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (age_en) begin
      age <= age_n;
    end
  end

  always_comb begin
    if (mode == REQ_LINE) begin
      req = busy && (age < len);
    end else begin
      req = busy && sched_active && (OFS_W'(sched_phase) < len);
    end
  end
endmodule

// File: rtl/ttx_pacer.sv
module ttx_pacer #(
  parameter int LINE_BITS    = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_HOLD    = 4,
  parameter int SHORT_HOLD   = 3,
  parameter int OFS_W        = 6,
  parameter int N_SRC        = 3,
  localparam int IDX_W = $clog2(LINE_BITS),
  localparam int PH_W  = $clog2(LONG_HOLD),
  localparam int SEL_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [SEL_W-1:0] cfg_src_sel,
  input  logic             cfg_req_mode,
  input  logic [OFS_W-1:0] cfg_req_lead,
  input  logic [OFS_W-1:0] cfg_req_len,
  input  logic             line_start,
  input  logic [N_SRC-1:0] src_pins,
  output logic             req_o,
  output logic             bit_valid,
  output logic             bit_data,
  output logic [IDX_W-1:0] bit_idx
);
  import ttx_pkg::*;

  line_st_t         state, state_n;
  logic [OFS_W-1:0] lead_cnt, lead_cnt_n;
  logic             accept;
  logic             d_start;
  logic             clr;
  logic             busy;

  logic             d_active, d_bit_end, d_line_end;
  logic [PH_W-1:0]  d_phase;
  logic [IDX_W-1:0] d_idx;
  logic             r_active, r_bit_end, r_line_end;
  logic [PH_W-1:0]  r_phase;
  logic [IDX_W-1:0] r_idx;
  logic             src_bit;

  logic             valid_n;

  always_comb begin
    clr     = !cfg_en;
    busy    = (state != ST_IDLE);
    accept  = cfg_en && line_start && (state == ST_IDLE);
    d_start = cfg_en && ((accept && (cfg_req_lead == '0)) ||
                         ((state == ST_LEAD) && (lead_cnt == '0)));
  end

  always_comb begin
    state_n    = state;
    lead_cnt_n = lead_cnt;
    if (!cfg_en) begin
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (line_start) begin
            if (cfg_req_lead == '0) begin
              state_n = ST_DATA;
            end else begin
              state_n    = ST_LEAD;
              lead_cnt_n = cfg_req_lead - 1'b1;
            end
          end
        end
        ST_LEAD: begin
          if (lead_cnt == '0) state_n = ST_DATA;
          else                lead_cnt_n = lead_cnt - 1'b1;
        end
        ST_DATA: begin
          if (d_line_end) state_n = ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lead_cnt <= '0;
    end else begin
      state    <= state_n;
      lead_cnt <= lead_cnt_n;
    end
  end

  // data schedule: starts after the programmed lead
  ttx_bit_timer #(
    .LINE_BITS   (LINE_BITS),
    .GROUP_BITS  (GROUP_BITS),
    .SHORT_STRIDE(SHORT_STRIDE),
    .LONG_HOLD   (LONG_HOLD),
    .SHORT_HOLD  (SHORT_HOLD)
  ) u_data_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .start   (d_start),
    .active  (d_active),
    .phase   (d_phase),
    .idx     (d_idx),
    .bit_end (d_bit_end),
    .line_end(d_line_end)
  );

  // request schedule: starts at once, runs ahead by the lead
  ttx_bit_timer #(
    .LINE_BITS   (LINE_BITS),
    .GROUP_BITS  (GROUP_BITS),
    .SHORT_STRIDE(SHORT_STRIDE),
    .LONG_HOLD   (LONG_HOLD),
    .SHORT_HOLD  (SHORT_HOLD)
  ) u_req_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .start   (accept),
    .active  (r_active),
    .phase   (r_phase),
    .idx     (r_idx),
    .bit_end (r_bit_end),
    .line_end(r_line_end)
  );

  ttx_src_mux #(
    .N_SRC(N_SRC),
    .SEL_W(SEL_W)
  ) u_mux (
    .pins(src_pins),
    .sel (cfg_src_sel),
    .dout(src_bit)
  );

  ttx_req_gen #(
    .OFS_W(OFS_W),
    .PH_W (PH_W)
  ) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .busy        (busy),
    .mode        (cfg_req_mode),
    .len         (cfg_req_len),
    .sched_active(r_active),
    .sched_phase (r_phase),
    .req         (req_o)
  );

  // capture at the last clock of each hold period
  always_comb begin
    valid_n = cfg_en && d_bit_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_data <= 1'b0;
      bit_idx  <= '0;
    end else if (valid_n) begin
      bit_data <= src_bit;
      bit_idx  <= d_idx;
    end
  end
endmodule

// File: rtl/ttx_pacer_chk.sv
module ttx_pacer_chk #(
  parameter int LINE_BITS = 360,
  parameter int IDX_W     = 9,
  parameter int SEL_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [SEL_W-1:0] cfg_src_sel,
  input logic             req_o,
  input logic             bit_valid,
  input logic             bit_data,
  input logic [IDX_W-1:0] bit_idx
);
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (int'(bit_idx) < LINE_BITS));

  // R1
  valid_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R1
  valid_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> ##1 !bit_valid);

  // R5
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!bit_valid && !req_o));

  // R6
  null_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_src_sel == SEL_W'(3)) |=> (!bit_valid || !bit_data));
endmodule

bind ttx_pacer ttx_pacer_chk #(
  .LINE_BITS(LINE_BITS),
  .IDX_W    (IDX_W),
  .SEL_W    (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_src_sel(cfg_src_sel),
  .req_o      (req_o),
  .bit_valid  (bit_valid),
  .bit_data   (bit_data),
  .bit_idx    (bit_idx)
);

// File: tb/ttx_pacer_bench.sv
module ttx_pacer_bench;
  localparam int CLK_P = 10;
  localparam int NB    = 360;

  logic       clk;
  logic       rst_n;
  logic       cfg_en;
  logic [1:0] cfg_src_sel;
  logic       cfg_req_mode;
  logic [5:0] cfg_req_lead;
  logic [5:0] cfg_req_len;
  logic       line_start;
  logic [2:0] src_pins;
  logic       req_o;
  logic       bit_valid;
  logic       bit_data;
  logic [8:0] bit_idx;

  int tests;
  int fails;
  int sched [0:NB];

  ttx_pacer u_ttx_pacer (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src_sel(cfg_src_sel),
    .cfg_req_mode(cfg_req_mode), .cfg_req_lead(cfg_req_lead),
    .cfg_req_len(cfg_req_len), .line_start(line_start), .src_pins(src_pins),
    .req_o(req_o), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_idx(bit_idx)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int hold_of(int k);
    int p;
    p = k % 37;
    return ((p != 0) && (p % 9 == 0)) ? 3 : 4;
  endfunction

  function automatic logic pat(int k);
    return logic'(((k * 13) ^ (k >> 2) ^ (k >> 5)) & 1);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one full line, optionally with a stray line-start or an abort
  task automatic run_line(input int lead, input int len, input logic mode,
                          input int sel, input int mid_at, input int abort_at);
    int p, qd, qr, n_end, nvalid;
    int err_t, err_d, err_r, first_t_a, first_t_e, first_r_n;
    int idle_err;
    logic aborted;
    logic v;
    @(negedge clk);
    cfg_en = 1'b1; cfg_src_sel = 2'(sel); cfg_req_mode = mode;
    cfg_req_lead = 6'(lead); cfg_req_len = 6'(len);
    @(negedge clk);
    line_start = 1'b1;
    p = 0; qd = 0; qr = 0; nvalid = 0;
    err_t = 0; err_d = 0; err_r = 0; first_t_a = 0; first_t_e = 0; first_r_n = -1;
    aborted = 1'b0;
    n_end = (abort_at >= 0) ? abort_at + 40 : lead + sched[NB] + 10;
    for (int n = 0; n <= n_end; n++) begin
      @(negedge clk);
      line_start = (n == mid_at) ? 1'b1 : 1'b0;
      if (n == abort_at) cfg_en = 1'b0;
      // drive the data pins for cycle n
      v = 1'b1;
      if (n - lead >= 0 && n - lead < sched[NB]) begin
        while (sched[qd + 1] <= n - lead) qd++;
        v = pat(qd);
      end
      src_pins = ~{3{v}};
      if (sel < 3) src_pins[sel] = v;
      else src_pins = {3{v}};
      // expected valid for cycle n
      if (!aborted && p < NB && n == lead + sched[p + 1]) begin
        nvalid++;
        if (!bit_valid || int'(bit_idx) != p) begin
          if (err_t == 0) begin first_t_a = n; first_t_e = p; end
          err_t++;
        end else if (bit_data != ((sel == 3) ? 1'b0 : pat(p))) begin
          err_d++;
        end
        p++;
      end else if (bit_valid) begin
        if (err_t == 0) begin first_t_a = n; first_t_e = -1; end
        err_t++;
      end
      // expected request for cycle n
      begin
        logic er;
        if (aborted) er = 1'b0;
        else if (mode == 1'b0) er = (n < len);
        else begin
          er = 1'b0;
          if (n < sched[NB]) begin
            while (sched[qr + 1] <= n) qr++;
            er = (n - sched[qr]) < len;
          end
        end
        if (req_o != er) begin
          if (first_r_n < 0) first_r_n = n;
          err_r++;
        end
      end
      if (n == abort_at) aborted = 1'b1;
    end
    chk(err_t == 0, (abort_at >= 0) ? "R5 abort valid timing" :
        (mid_at >= 0 ? "R4 stray start timing" : "R1 R2 valid timing"),
        first_t_a, first_t_e);
    chk(err_d == 0, (sel == 3) ? "R6 null source data" : "R6 selected pin data",
        err_d, 0);
    chk(err_r == 0, mode ? "R8 bit-mode request" : "R7 line-mode request",
        first_r_n, -1);
    if (abort_at < 0) begin
      chk(nvalid == NB, "R3 bit count per line", nvalid, NB);
      idle_err = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        src_pins = 3'b111;
        if (bit_valid || req_o) idle_err++;
      end
      chk(idle_err == 0, "R3 idle after line", idle_err, 0);
    end
    cfg_en = 1'b1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_o && !bit_valid && !bit_data && bit_idx == '0, "R9 reset outputs",
        int'({req_o, bit_valid, bit_data}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_disabled();
    int errs;
    errs = 0;
    @(negedge clk);
    cfg_en = 1'b0; cfg_req_mode = 1'b0; cfg_req_len = 6'd10; cfg_req_lead = 6'd0;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bit_valid || req_o) errs++;
    end
    chk(errs == 0, "R5 start ignored when disabled", errs, 0);
    cfg_en = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    sched[0] = 0;
    for (int k = 0; k < NB; k++) sched[k + 1] = sched[k] + hold_of(k);
    cfg_en = 1'b0; cfg_src_sel = 2'd0; cfg_req_mode = 1'b0;
    cfg_req_lead = '0; cfg_req_len = '0; line_start = 1'b0; src_pins = '0;
    rst_n = 1'b0;
    test_reset();
    run_line(0, 5, 1'b0, 0, -1, -1);
    run_line(7, 3, 1'b1, 1, 500, -1);
    run_line(2, 4, 1'b1, 2, 1, -1);
    run_line(63, 63, 1'b0, 3, -1, -1);
    run_line(4, 10, 1'b1, 0, -1, -1);
    test_disabled();
    run_line(5, 2, 1'b1, 0, -1, 300);
    run_line(0, 6, 1'b1, 1, -1, -1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule